// File: doc/BRIEF.md
# Two-Wire Serial Word Programming Target

This block is the device end of a two-wire programming link made of a serial clock and a data line. While idle it watches both lines for a fixed start pattern. When it sees that pattern it clears its whole word store to zero over a timed erase interval. It then collects serial bits into words and commits each word to the next address, starting from address zero.

After each word the target runs a timed write interval. A programmer that polls by holding the serial clock high sees the data line pulled low while the write is busy, and driven high once it has finished. When the last word has been acknowledged, the programmer can keep clocking to read the store back exactly once, in address order.

Both serial inputs arrive already synchronised to the system clock. The data line is split into an input, an output and an output enable. A separate registered read port gives test logic direct access to the store.

Top module: `prog_target`

## Requirements
- R1: A session opens only after this sequence: the serial clock rises while data is low, then data rises while the clock is high, then both lines are seen low in the same sample. Any other ordering leaves the block idle, and an idle block never drives the data line.
- R2: After a session opens, every word of the store reads zero once the erase interval of ERASE_CYC system cycles has passed.
- R3: Data bits are taken on falling serial clock edges, least significant bit first, WORD_W bits per word. The first word goes to address 0 and each later word goes to the next address.
- R4: While a word write is in progress, the block drives the data line low whenever the serial clock is high.
- R5: Once the write interval of WRITE_CYC cycles ends, the block drives the data line high while the serial clock stays high. It stops driving when the clock goes low.
- R6: Bits at positions USED_W and above are discarded and read back as zero.
- R7: While words are being received, the block leaves the data line undriven.
- R8: After the last word is acknowledged, each falling clock edge moves readback on by one bit. Each bit is valid while the clock is high, least significant bit first, from address 0 upward, with no acknowledge between words.
- R9: After the single readback pass, further clocks only read zeros, with the line driven, until reset.
- R10: Serial clock edges that arrive during the erase or write interval are ignored and change neither stored data nor bit count.
- R11: The test read port returns the word at rd_addr one system cycle after the address is presented.
- R12: After reset the data line is undriven and the output bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk | input | 1 | Synchronised serial clock |
| pdat_in | input | 1 | Synchronised serial data from the programmer |
| pdat_out | output | 1 | Serial data driven by the target |
| pdat_oe | output | 1 | High when the target drives the data line |
| rd_addr | input | AW | Test read address |
| rd_data | output | WORD_W | Test read data, one cycle latency |

## Verification
The checker watches the line-driving rules on every cycle. These are: low while busy with the clock high, high during the acknowledge, released while receiving and after the acknowledge clock falls, and zeros once the pass is spent. It also checks that the write address never exceeds the word count and that the bit count stays frozen during writes. Only the bench scenarios can show the behaviour that depends on data. That covers bit order and address order, masking of the upper bits, erase of an earlier session's contents, immunity to clock glitches during timed intervals, rejection of wrong start patterns, and the exact bit stream of the readback pass.

// File: rtl/prog_target_pkg.sv
package prog_target_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE,
    ST_RECV,
    ST_WRITE,
    ST_ACK,
    ST_VLOAD,
    ST_VLATCH,
    ST_VERIFY,
    ST_DONE
  } tgt_state_t;
endpackage

// File: rtl/prog_entry_det.sv
module prog_entry_det (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic clk_now,
  input  logic clk_was,
  input  logic dat_now,
  input  logic dat_was,
  output logic hit
);
  typedef enum logic [1:0] {E_WAIT, E_CLKHI, E_BOTHHI} ent_t;
  ent_t es_q;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      es_q <= E_WAIT;
    end else begin
      case (es_q)
        E_WAIT:   if (clk_now && !clk_was && !dat_now) es_q <= E_CLKHI;
        E_CLKHI: begin
          if (!clk_now)                          es_q <= E_WAIT;
          else if (dat_now && !dat_was)          es_q <= E_BOTHHI;
        end
        E_BOTHHI: if (!clk_now || !dat_now)      es_q <= E_WAIT;
        default:                                 es_q <= E_WAIT;
      endcase
    end
  end

  assign hit = arm && (es_q == E_BOTHHI) && !clk_now && !dat_now;
endmodule

// File: rtl/prog_word_mem.sv
module prog_word_mem #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 12,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [AW-1:0]    ra_a,
  output logic [WIDTH-1:0] rd_a,
  input  logic [AW-1:0]    ra_b,
  output logic [WIDTH-1:0] rd_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(wa) < DEPTH)) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    rd_a <= (int'(ra_a) < DEPTH) ? mem[ra_a] : '0;
    rd_b <= (int'(ra_b) < DEPTH) ? mem[ra_b] : '0;
  end
endmodule

// File: rtl/prog_target.sv
module prog_target
  import prog_target_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int USED_W    = 16,
  parameter int NUM_WORDS = 12,
  parameter int ERASE_CYC = 800,
  parameter int WRITE_CYC = 1000,
  localparam int AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pclk,
  input  logic              pdat_in,
  output logic              pdat_out,
  output logic              pdat_oe,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int CW  = $clog2(NUM_WORDS + 1);
  localparam int BW  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int TMAX = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
  localparam int TW  = $clog2(TMAX + 1);
  localparam logic [TW-1:0] ERASE_LAST = TW'(ERASE_CYC - 1);
  localparam logic [TW-1:0] WRITE_LAST = TW'(WRITE_CYC - 1);
  localparam logic [TW-1:0] NW_T       = TW'(NUM_WORDS);
  localparam logic [BW-1:0] BIT_LAST   = BW'(WORD_W - 1);
  localparam logic [CW-1:0] WA_END     = CW'(NUM_WORDS);
  localparam logic [AW-1:0] RA_LAST    = AW'(NUM_WORDS - 1);

  tgt_state_t        st_q;
  logic              pclk_q, pdat_q;
  logic [TW-1:0]     timer_q;
  logic [CW-1:0]     waddr_q;
  logic [BW-1:0]     bitcnt_q;
  logic [WORD_W-1:0] shreg_q;
  logic [AW-1:0]     raddr_q;
  logic [WORD_W-1:0] vword;
  logic [WORD_W-1:0] keep;
  logic              fall, hit;
  logic              mem_we;
  logic [AW-1:0]     mem_wa;
  logic [WORD_W-1:0] mem_wd, next_word;

  always_comb begin
    for (int i = 0; i < WORD_W; i++) keep[i] = (i < USED_W);
  end

  assign fall      = pclk_q && !pclk;
  assign next_word = {pdat_in, shreg_q[WORD_W-1:1]};

  prog_entry_det u_entry (
    .clk     (clk),
    .rst     (rst),
    .arm     (st_q == ST_IDLE),
    .clk_now (pclk),
    .clk_was (pclk_q),
    .dat_now (pdat_in),
    .dat_was (pdat_q),
    .hit     (hit)
  );

  always_comb begin
    mem_we = 1'b0;
    mem_wa = waddr_q[AW-1:0];
    mem_wd = next_word & keep;
    if (st_q == ST_ERASE) begin
      mem_we = (timer_q < NW_T);
      mem_wa = timer_q[AW-1:0];
      mem_wd = '0;
    end else if (st_q == ST_RECV) begin
      mem_we = fall && (bitcnt_q == BIT_LAST);
    end
  end

  prog_word_mem #(.WIDTH(WORD_W), .DEPTH(NUM_WORDS)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .wa   (mem_wa),
    .wd   (mem_wd),
    .ra_a (rd_addr),
    .rd_a (rd_data),
    .ra_b (raddr_q),
    .rd_b (vword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pclk_q   <= 1'b0;
      pdat_q   <= 1'b0;
      timer_q  <= '0;
      waddr_q  <= '0;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      raddr_q  <= '0;
      pdat_oe  <= 1'b0;
      pdat_out <= 1'b0;
    end else begin
      pclk_q   <= pclk;
      pdat_q   <= pdat_in;
      pdat_oe  <= (((st_q == ST_WRITE) || (st_q == ST_ACK)) && pclk) ||
                  (st_q == ST_VERIFY) || (st_q == ST_DONE);
      pdat_out <= ((st_q == ST_ACK) && pclk) ||
                  ((st_q == ST_VERIFY) && shreg_q[0]);
      case (st_q)
        ST_IDLE: if (hit) begin
          st_q    <= ST_ERASE;
          timer_q <= '0;
        end
        ST_ERASE: begin
          timer_q <= timer_q + 1'b1;
          if (timer_q == ERASE_LAST) begin
            st_q     <= ST_RECV;
            timer_q  <= '0;
            waddr_q  <= '0;
            bitcnt_q <= '0;
          end
        end
        ST_RECV: if (fall) begin
          shreg_q  <= next_word;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q == BIT_LAST) begin
            st_q     <= ST_WRITE;
            timer_q  <= '0;
            bitcnt_q <= '0;
          end
        end
        ST_WRITE: begin
          timer_q <= timer_q + 1'b1;
          if (timer_q == WRITE_LAST) begin
            st_q    <= ST_ACK;
            waddr_q <= waddr_q + 1'b1;
          end
        end
        ST_ACK: if (!pclk) begin
          if (waddr_q == WA_END) begin
            st_q     <= ST_VLOAD;
            raddr_q  <= '0;
            bitcnt_q <= '0;
          end else begin
            st_q <= ST_RECV;
          end
        end
        ST_VLOAD:  st_q <= ST_VLATCH;
        ST_VLATCH: begin
          shreg_q <= vword;
          st_q    <= ST_VERIFY;
        end
        ST_VERIFY: if (fall) begin
          shreg_q  <= shreg_q >> 1;
          bitcnt_q <= bitcnt_q + 1'b1;
          if (bitcnt_q == BIT_LAST) begin
            bitcnt_q <= '0;
            if (raddr_q == RA_LAST) begin
              st_q <= ST_DONE;
            end else begin
              raddr_q <= raddr_q + 1'b1;
              st_q    <= ST_VLOAD;
            end
          end
        end
        ST_DONE:  st_q <= ST_DONE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prog_target_chk.sv
module prog_target_chk
  import prog_target_pkg::*;
#(
  parameter int CW = 4,
  parameter int BW = 4,
  parameter int NUM_WORDS = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          pclk,
  input logic          pdat_oe,
  input logic          pdat_out,
  input tgt_state_t    st,
  input logic [CW-1:0] waddr,
  input logic [BW-1:0] bitcnt
);
  a_r4_busy_low: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WRITE && pclk) |=> (pdat_oe && !pdat_out));

  a_r5_ack_high: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && pclk) |=> (pdat_oe && pdat_out));

  a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && !pclk) |=> !pdat_oe);

  a_r7_recv_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECV) |=> !pdat_oe);

  a_r9_spent_zero: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |=> (pdat_oe && !pdat_out));

  a_r3_addr_bound: assert property (@(posedge clk) disable iff (rst)
    int'(waddr) <= NUM_WORDS);

  a_r10_write_frozen: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WRITE) |-> (bitcnt == '0));

  a_r12_reset_idle: assert property (@(posedge clk)
    rst |=> (!pdat_oe && !pdat_out));
endmodule

bind prog_target prog_target_chk #(
  .CW(CW), .BW(BW), .NUM_WORDS(NUM_WORDS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pclk     (pclk),
  .pdat_oe  (pdat_oe),
  .pdat_out (pdat_out),
  .st       (st_q),
  .waddr    (waddr_q),
  .bitcnt   (bitcnt_q)
);

// File: tb/test_prog_target.sv
`timescale 1ns/1ps
module test_prog_target;
  localparam int W  = 16;
  localparam int U  = 14;
  localparam int N  = 6;
  localparam int EC = 40;
  localparam int WC = 30;
  localparam int AWB = $clog2(N);

  logic clk = 1'b0, rst = 1'b1, pclk = 1'b0, pdat = 1'b0;
  logic pdat_out, pdat_oe;
  logic [AWB-1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] exp_mem [N];
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  prog_target #(.WORD_W(W), .USED_W(U), .NUM_WORDS(N),
                .ERASE_CYC(EC), .WRITE_CYC(WC)) i_prog_target (
    .clk(clk), .rst(rst), .pclk(pclk), .pdat_in(pdat),
    .pdat_out(pdat_out), .pdat_oe(pdat_oe),
    .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [W-1:0] masked(input logic [W-1:0] w);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < U);
    return w & m;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enter_session();
    pdat = 0; pclk = 0; wait_cyc(3);
    pclk = 1; wait_cyc(3);
    pdat = 1; wait_cyc(3);
    pclk = 0; pdat = 0; wait_cyc(2);
  endtask

  task automatic send_word(input logic [W-1:0] w, input int idx,
                           input bit glitch, input bit last);
    for (int i = 0; i < W; i++) begin
      pdat = w[i]; pclk = 1; wait_cyc(4);
      if (i == 0) check("R7 line released in receive", pdat_oe, 0);
      pclk = 0; wait_cyc(4);
    end
    pclk = 1; wait_cyc(3);
    check("R4 busy drives low", {pdat_oe, pdat_out}, 2'b10);
    if (glitch) begin
      pdat = 1; pclk = 0; wait_cyc(2); pclk = 1; wait_cyc(2);
    end
    wait_cyc(WC + 4);
    check("R5 done drives high", {pdat_oe, pdat_out}, 2'b11);
    pclk = 0; wait_cyc(3);
    if (!last) check("R5 release on clock low", pdat_oe, 0);
    exp_mem[idx] = masked(w);
  endtask

  task automatic verify_pass();
    wait_cyc(6);
    for (int a = 0; a < N; a++) begin
      for (int i = 0; i < W; i++) begin
        pclk = 1; wait_cyc(4);
        check($sformatf("R8 readback word %0d bit %0d", a, i),
              {pdat_oe, pdat_out}, {1'b1, exp_mem[a][i]});
        pclk = 0; wait_cyc(4);
      end
    end
    for (int i = 0; i < W; i++) begin
      pclk = 1; wait_cyc(4);
      check("R9 second pass reads zero", {pdat_oe, pdat_out}, 2'b10);
      pclk = 0; wait_cyc(4);
    end
  endtask

  task automatic check_store(input string req);
    for (int a = 0; a < N; a++) begin
      rd_addr = AWB'(a); wait_cyc(1);
      check(req, rd_data, exp_mem[a]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5eed_2024);
    wait_cyc(5);
    check("R12 reset state", {pdat_oe, pdat_out}, 2'b00);
    rst = 0; wait_cyc(3);

    // R1: wrong orderings must not open a session
    pdat = 1; wait_cyc(3); pclk = 1; wait_cyc(3); pclk = 0; pdat = 0; wait_cyc(3);
    pclk = 1; wait_cyc(3); pclk = 0; wait_cyc(3); pdat = 1; wait_cyc(3); pdat = 0; wait_cyc(3);
    for (int i = 0; i < W; i++) begin
      pdat = 1; pclk = 1; wait_cyc(4); pclk = 0; wait_cyc(4);
    end
    pclk = 1; wait_cyc(WC + 10);
    check("R1 no session after bad pattern", pdat_oe, 0);
    pclk = 0; wait_cyc(3);

    // Session A: random words, glitch during write of word 1 (R10)
    enter_session();
    wait_cyc(EC + 10);
    for (int k = 0; k < N; k++)
      send_word(W'($urandom), k, k == 1, k == N - 1);
    check_store("R3 R6 R11 store after session A");
    verify_pass();

    // Session B: previous content must be erased (R2), erase glitches ignored (R10)
    rst = 1; wait_cyc(3); rst = 0; wait_cyc(3);
    enter_session();
    wait_cyc(5);
    for (int i = 0; i < 2; i++) begin
      pdat = 1; pclk = 1; wait_cyc(4); pclk = 0; wait_cyc(4);
    end
    wait_cyc(EC + 10);
    for (int a = 0; a < N; a++) exp_mem[a] = '0;
    check_store("R2 erased to zero");
    send_word(16'hFFFF, 0, 0, 0);
    send_word(16'h0001, 1, 0, 0);
    send_word(16'h8000, 2, 1, 0);
    send_word(16'hC000, 3, 0, 0);
    send_word(16'h2AA5, 4, 0, 0);
    send_word(W'($urandom), 5, 1, 1);
    check_store("R3 R6 R10 store after session B");
    verify_pass();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule